// File: doc/BRIEF.md
# Flash Double-Word Program Sequencer

The block runs the host-driven sequence that programs one 64-bit double word of an embedded flash array. Two array blocks are modelled behaviourally as small register files. Each block has its own control register with a program-mode bit, an erase-mode bit and a high-voltage enable bit. The host enables program mode and makes a first data write, called the interlock write. That write fixes the target block and row and loads one 32-bit word. The host may then write the other word. Setting high-voltage enable launches a programming run of fixed length.

When the run ends, the block raises a done flag and reports pass or fail. Programming can only clear bits. A locked block, or a launch with no interlock write, ends in failure and leaves the array unchanged. While either block holds a mode bit, mode requests to the other block are refused. The host clears high-voltage enable to retire the run and clears the mode bits to deselect.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, every mode, enable, done and pass output is low and every double word of both blocks reads all ones.
- R2: The first accepted data write in program mode (the interlock write) latches block (address MSB) and row (double-word address) and loads the word chosen by address bit 2 (0 = low word, 1 = high word). The word left unwritten before launch programs as 0xFFFF_FFFF.
- R3: Later data writes in the same sequence ignore their block and row bits and only use bit 2 to pick the word of the latched double word they replace.
- R4: A successful run stores old AND supplied data, so no stored bit ever goes from 0 to 1.
- R5: A run that targets a block whose lock_i bit is high ends with done high and pass low, and the array is unchanged.
- R6: Done rises exactly PROG_CYCLES clock cycles after the edge that accepts the launch write. It stays high until a control write clears high-voltage enable, and it drops at that edge.
- R7: A run with a valid interlock, program mode set and an unlocked block ends with pass high.
- R8: A control write that sets program mode or erase mode in one block is ignored while the other block holds either mode bit.
- R9: Clearing program mode before launch abandons the interlock. A later launch without a new interlock write fails and leaves the array unchanged.
- R10: Launching with no interlock write ends with done high and pass low, and no double word changes.
- R11: While high-voltage enable is set, control writes cannot change the program-mode or erase-mode bits.
- R12: High-voltage enable is set only by a write that also carries a mode bit. Control encoding: bit0 program mode, bit1 erase mode, bit2 high-voltage enable. Data writes are ignored outside program mode and while a run is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_blk_i | input | BLK_W | Block addressed by the control write |
| ctl_wdata_i | input | 3 | Control value: bit0 program mode, bit1 erase mode, bit2 high-voltage enable |
| dat_we_i | input | 1 | Array data write strobe |
| dat_addr_i | input | AW-2 | Word address: {block, row, word select} |
| dat_wdata_i | input | 32 | Program data word |
| lock_i | input | NBLK | Per-block program lock |
| rd_addr_i | input | AW-3 | Double-word read address: {block, row} |
| rd_data_o | output | 64 | Stored double word at rd_addr_i |
| pgm_o | output | NBLK | Program-mode bit per block |
| ers_o | output | NBLK | Erase-mode bit per block |
| ehv_o | output | NBLK | High-voltage enable bit per block |
| done_o | output | NBLK | Run complete per block |
| pass_o | output | NBLK | Last run succeeded per block |

## Verification
Several properties are checked on every cycle. At most one block holds a mode bit at any time. Done is never high without high-voltage enable, and it rises only after a run. The mode bits stay frozen through a run. No stored array bit ever rises. Other behaviour can only be shown by the directed scenarios: the value a run writes, including the all-ones fill, the AND merge and the second-write address rules; the exact done latency; and the failures caused by a lock, a missing interlock or an abandoned interlock.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam int DW_W   = 64;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic ehv;
    logic ers;
    logic pgm;
  } ctl_t;
endpackage

// File: rtl/flash_blk_seq.sv
module flash_blk_seq
  import flash_prog_pkg::*;
#(
  parameter int ROW_W       = 4,
  parameter int PROG_CYCLES = 8,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [2:0]        ctl_i,
  input  logic              deny_i,
  input  logic              dat_we_i,
  input  logic              dat_hit_i,
  input  logic              dat_word_i,
  input  logic [ROW_W-1:0]  dat_row_i,
  input  logic [WORD_W-1:0] dat_i,
  input  logic              lock_i,
  output logic              pgm_o,
  output logic              ers_o,
  output logic              ehv_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              wr_en_o,
  output logic [ROW_W-1:0]  wr_row_o,
  output logic [DW_W-1:0]   wr_data_o
);
  localparam logic [WORD_W-1:0] ONES = '1;

  ctl_t              ctl;
  logic              pgm_q, ers_q, ehv_q, done_q, pass_q, il_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ROW_W-1:0]  row_q;
  logic [DW_W-1:0]   buf_q;
  logic              fin, ok;

  assign ctl = ctl_t'(ctl_i);
  assign fin = ehv_q && !done_q && (cnt_q == '0);
  assign ok  = il_q && pgm_q && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_q  <= 1'b0;
      ers_q  <= 1'b0;
      ehv_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      il_q   <= 1'b0;
      cnt_q  <= '0;
      row_q  <= '0;
      buf_q  <= '1;
    end else begin
      // run countdown
      if (ehv_q && !done_q) begin
        if (cnt_q == '0) begin
          done_q <= 1'b1;
          pass_q <= ok;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      // control register
      if (ctl_we_i) begin
        if (ehv_q) begin
          if (!ctl.ehv) begin
            ehv_q  <= 1'b0;
            done_q <= 1'b0;
            il_q   <= 1'b0;
          end
        end else if (!(deny_i && (ctl.pgm || ctl.ers))) begin
          pgm_q <= ctl.pgm;
          ers_q <= ctl.ers;
          if (!ctl.pgm) il_q <= 1'b0;
          if (ctl.ehv && (ctl.pgm || ctl.ers)) begin
            ehv_q  <= 1'b1;
            done_q <= 1'b0;
            pass_q <= 1'b0;
            cnt_q  <= CNT_W'(PROG_CYCLES - 1);
          end
        end
      end
      // data writes
      if (dat_we_i && pgm_q && !ehv_q) begin
        if (!il_q) begin
          if (dat_hit_i) begin
            il_q  <= 1'b1;
            row_q <= dat_row_i;
            buf_q <= dat_word_i ? {dat_i, ONES} : {ONES, dat_i};
          end
        end else if (dat_word_i) begin
          buf_q[DW_W-1:WORD_W] <= dat_i;
        end else begin
          buf_q[WORD_W-1:0] <= dat_i;
        end
      end
    end
  end

  assign pgm_o     = pgm_q;
  assign ers_o     = ers_q;
  assign ehv_o     = ehv_q;
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign wr_en_o   = fin && ok;
  assign wr_row_o  = row_q;
  assign wr_data_o = buf_q;

  AST_DONE_NEEDS_EHV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ehv_q); // R6
  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(ehv_q)); // R6
  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ehv_q) |-> ($stable(pgm_q) && $stable(ers_q))); // R11
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_prog_pkg::*;
#(
  parameter int NBLK  = 2,
  parameter int ROW_W = 4,
  parameter int BLK_W = 1,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i   [NBLK],
  input  logic [ROW_W-1:0] wr_row_i  [NBLK],
  input  logic [DW_W-1:0]  wr_data_i [NBLK],
  input  logic [BLK_W-1:0] rd_blk_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic [DW_W-1:0]  rd_data_o
);
  logic [DW_W-1:0] mem_q [NBLK][DEPTH];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    for (genvar r = 0; r < DEPTH; r++) begin : g_row
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[b][r] <= '1;
        else if (wr_en_i[b] && (wr_row_i[b] == ROW_W'(r)))
          mem_q[b][r] <= mem_q[b][r] & wr_data_i[b];
      end

      AST_NO_BIT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((mem_q[b][r] & ~$past(mem_q[b][r])) == '0)); // R4
    end
  end

  assign rd_data_o = mem_q[rd_blk_i][rd_row_i];
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int NBLK        = 2,
  parameter int DEPTH       = 16,
  parameter int PROG_CYCLES = 8,
  localparam int ROW_W      = $clog2(DEPTH),
  localparam int BLK_W      = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int AW         = BLK_W + ROW_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [BLK_W-1:0]  ctl_blk_i,
  input  logic [2:0]        ctl_wdata_i,
  input  logic              dat_we_i,
  input  logic [AW-1:2]     dat_addr_i,
  input  logic [31:0]       dat_wdata_i,
  input  logic [NBLK-1:0]   lock_i,
  input  logic [AW-1:3]     rd_addr_i,
  output logic [63:0]       rd_data_o,
  output logic [NBLK-1:0]   pgm_o,
  output logic [NBLK-1:0]   ers_o,
  output logic [NBLK-1:0]   ehv_o,
  output logic [NBLK-1:0]   done_o,
  output logic [NBLK-1:0]   pass_o
);
  logic [NBLK-1:0]  mode;
  logic             wr_en   [NBLK];
  logic [ROW_W-1:0] wr_row  [NBLK];
  logic [DW_W-1:0]  wr_data [NBLK];

  logic [BLK_W-1:0] dat_blk;
  logic [ROW_W-1:0] dat_row;
  assign dat_blk = dat_addr_i[AW-1 -: BLK_W];
  assign dat_row = dat_addr_i[ROW_W+2:3];
  assign mode    = pgm_o | ers_o;

  for (genvar b = 0; b < NBLK; b++) begin : g_seq
    logic deny;
    // another block already owns a modify operation
    assign deny = |(mode & ~(NBLK'(1) << b));

    flash_blk_seq #(
      .ROW_W      (ROW_W),
      .PROG_CYCLES(PROG_CYCLES)
    ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_we_i  (ctl_we_i && (ctl_blk_i == BLK_W'(b))),
      .ctl_i     (ctl_wdata_i),
      .deny_i    (deny),
      .dat_we_i  (dat_we_i),
      .dat_hit_i (dat_blk == BLK_W'(b)),
      .dat_word_i(dat_addr_i[2]),
      .dat_row_i (dat_row),
      .dat_i     (dat_wdata_i),
      .lock_i    (lock_i[b]),
      .pgm_o     (pgm_o[b]),
      .ers_o     (ers_o[b]),
      .ehv_o     (ehv_o[b]),
      .done_o    (done_o[b]),
      .pass_o    (pass_o[b]),
      .wr_en_o   (wr_en[b]),
      .wr_row_o  (wr_row[b]),
      .wr_data_o (wr_data[b])
    );
  end

  flash_array #(
    .NBLK (NBLK),
    .ROW_W(ROW_W),
    .BLK_W(BLK_W)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_row_i (wr_row),
    .wr_data_i(wr_data),
    .rd_blk_i (rd_addr_i[AW-1 -: BLK_W]),
    .rd_row_i (rd_addr_i[ROW_W+2:3]),
    .rd_data_o(rd_data_o)
  );

  AST_ONE_MODIFY_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode) <= 1); // R8
  AST_RUN_HAS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ehv_o & ~mode) == '0); // R12
endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
  localparam int CYC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [0:0]  ctl_blk = '0;
  logic [2:0]  ctl_wdata = '0;
  logic        dat_we = 1'b0;
  logic [7:2]  dat_addr = '0;
  logic [31:0] dat_wdata = '0;
  logic [1:0]  lock = '0;
  logic [7:3]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [1:0]  pgm, ers, ehv, done, pass;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #10 clk = ~clk; // 50 MHz, 1 ns units

  flash_prog_seq #(.NBLK(2), .DEPTH(16), .PROG_CYCLES(CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_blk_i(ctl_blk), .ctl_wdata_i(ctl_wdata),
    .dat_we_i(dat_we), .dat_addr_i(dat_addr), .dat_wdata_i(dat_wdata),
    .lock_i(lock), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pgm_o(pgm), .ers_o(ers), .ehv_o(ehv), .done_o(done), .pass_o(pass)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:2] wa(input int b, input int r, input int w);
    return {b[0], r[3:0], w[0]};
  endfunction

  task automatic ctl_wr(input int b, input logic [2:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_blk = b[0]; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic dat_wr(input logic [7:2] a, input logic [31:0] d);
    @(negedge clk);
    dat_we = 1'b1; dat_addr = a; dat_wdata = d;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int b, input int r, input logic [63:0] exp);
    rd_addr = {b[0], r[3:0]};
    #1;
    chk(tag, rd_data, exp);
  endtask

  // launch, check exact done latency and pass, retire run, deselect
  task automatic launch(input int b, input logic exp_pass, input string tag);
    ctl_wr(b, 3'b101);
    repeat (CYC - 1) @(negedge clk);
    chk("R6 done not early", 64'(done[b]), 64'd0);
    @(negedge clk);
    chk("R6 done on time", 64'(done[b]), 64'd1);
    chk(tag, 64'(pass[b]), 64'(exp_pass));
    repeat (3) @(negedge clk);
    chk("R6 done holds", 64'(done[b]), 64'd1);
    ctl_wr(b, 3'b001);
    chk("R6 done drops", 64'(done[b]), 64'd0);
    ctl_wr(b, 3'b000);
  endtask

  task automatic t_reset;
    chk("R1 status", {pgm, ers, ehv, done, pass}, '0);
    rd_chk("R1 blk0", 0, 0, '1);
    rd_chk("R1 blk1", 1, 15, '1);
  endtask

  task automatic t_full;
    ctl_wr(0, 3'b001);
    dat_wr(wa(0, 3, 0), 32'h1234_5678);
    dat_wr(wa(1, 9, 1), 32'hA5A5_0F0F); // R3 foreign block/row bits
    launch(0, 1'b1, "R7 pass full");
    rd_chk("R2 R3 full dword", 0, 3, 64'hA5A5_0F0F_1234_5678);
    rd_chk("R3 other addr untouched", 1, 9, '1);
  endtask

  task automatic t_single;
    ctl_wr(1, 3'b001);
    dat_wr(wa(1, 5, 1), 32'h0F0F_F0F0);
    launch(1, 1'b1, "R7 pass single");
    rd_chk("R2 fill ones", 1, 5, 64'h0F0F_F0F0_FFFF_FFFF);
  endtask

  task automatic t_and;
    ctl_wr(0, 3'b001);
    dat_wr(wa(0, 3, 0), 32'hFFFF_0000);
    dat_wr(wa(0, 3, 1), 32'hFFFF_FFFF);
    dat_wr(wa(0, 3, 1), 32'h0000_FFFF); // R3 last write wins
    launch(0, 1'b1, "R7 pass and");
    rd_chk("R4 and merge", 0, 3, 64'h0000_0F0F_1234_0000);
  endtask

  task automatic t_lock;
    lock = 2'b01;
    ctl_wr(0, 3'b001);
    dat_wr(wa(0, 7, 0), 32'h0);
    dat_wr(wa(0, 7, 1), 32'h0);
    launch(0, 1'b0, "R5 locked fails");
    rd_chk("R5 locked unchanged", 0, 7, '1);
    lock = 2'b00;
  endtask

  task automatic t_lockout;
    ctl_wr(0, 3'b001);
    ctl_wr(1, 3'b001);
    chk("R8 pgm refused", 64'(pgm), 64'b01);
    ctl_wr(1, 3'b010);
    chk("R8 ers refused", 64'(ers), 64'b00);
    ctl_wr(0, 3'b000);
    ctl_wr(1, 3'b010);
    chk("R8 ers accepted", 64'(ers), 64'b10);
    ctl_wr(0, 3'b001);
    chk("R8 reverse refused", 64'(pgm), 64'b00);
    ctl_wr(1, 3'b000);
  endtask

  task automatic t_no_interlock;
    ctl_wr(0, 3'b001);
    launch(0, 1'b0, "R10 no interlock fails");
    rd_chk("R10 row0 unchanged", 0, 0, '1);
  endtask

  task automatic t_abandon;
    ctl_wr(0, 3'b001);
    dat_wr(wa(0, 2, 0), 32'h0);
    ctl_wr(0, 3'b000);
    ctl_wr(0, 3'b001);
    launch(0, 1'b0, "R9 abandoned fails");
    rd_chk("R9 row2 unchanged", 0, 2, '1);
  endtask

  task automatic t_frozen;
    int k;
    ctl_wr(1, 3'b001);
    dat_wr(wa(1, 11, 0), 32'h0);
    ctl_wr(1, 3'b101);
    ctl_wr(1, 3'b110);
    chk("R11 pgm kept", 64'(pgm[1]), 64'd1);
    chk("R11 ers kept", 64'(ers[1]), 64'd0);
    dat_wr(wa(1, 11, 1), 32'h0); // R12 ignored during run
    k = 0;
    while (!done[1] && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk("R7 frozen run pass", 64'(pass[1]), 64'd1);
    ctl_wr(1, 3'b001);
    ctl_wr(1, 3'b000);
    rd_chk("R12 run-time write ignored", 1, 11, 64'hFFFF_FFFF_0000_0000);
  endtask

  task automatic t_no_mode;
    ctl_wr(0, 3'b100);
    chk("R12 ehv needs mode", 64'(ehv), 64'd0);
    dat_wr(wa(0, 4, 0), 32'h0); // not in program mode
    ctl_wr(0, 3'b001);
    launch(0, 1'b0, "R12 idle write no interlock");
    rd_chk("R12 row4 unchanged", 0, 4, '1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_single();
    t_and();
    t_lock();
    t_lockout();
    t_no_interlock();
    t_abandon();
    t_frozen();
    t_no_mode();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule